// File: doc/BRIEF.md
# Dynamic Memory Array Strobe Sequencer

This block is a synchronous controller for the control strobes of a small dynamic memory array built from one-transistor cells. A requester hands it one access at a time over a ready/valid handshake: a read or a write, with a row and a column address and, for a write, one data word. For every access the controller steps through the same fixed sequence of phases. It charges and equalizes the bit lines, opens the word line of the selected row and waits for the bit lines to separate. It then fires the sense amplifiers and captures the whole row, drives the captured row back into the cells and closes the row. The length of each phase is a parameter counted in clock cycles.

Sensing a one-transistor cell discharges it, so every access ends with a write-back of the full row. A write merges the new word into the captured row before that write-back. A read returns its word with a one-cycle valid pulse as soon as sensing ends. A free-running timer asks for one row refresh every `REF_PERIOD` cycles. A refresh runs the same sequence with no column selected and no data returned. A pointer steps through the rows in ascending order and wraps. A pending refresh wins against a new request when the controller is idle, and it never cuts into an access that has already started.

States: `ST_IDLE` (waiting; takes a pending refresh first, otherwise a handshake) → `ST_PRECH` (bit-line charge and equalize, `T_PRE` cycles) → `ST_SETTLE` (word line up, `T_WL` cycles) → `ST_SENSE` (sense amplifiers on, `T_SENSE` cycles; row captured on the last cycle) → `ST_RESTORE` (row driven back, `T_RST` cycles) → `ST_CLOSE` (all strobes low, `T_CLOSE` cycles) → `ST_IDLE`. Each transition out of a non-idle state fires when that phase's counter expires.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: Directly after reset all strobes, `row_sel`, `col_sel` and `rd_valid` are low and `req_ready` is high.
- R2: Every access starts with `pre_en` and `eq_en` both high for exactly `T_PRE` cycles, and the word line is raised in the cycle right after precharge ends.
- R3: `pre_en` and `wl_en` are never high in the same cycle.
- R4: `sense_en` rises only after `wl_en` has been high for exactly `T_WL` cycles, and `sense_en` is high only while `wl_en` is high.
- R5: Every opened row is written back: `wr_drv` is high for exactly `T_RST` cycles before `wl_en` falls, and the row that was sensed gets back the sensed contents (with the written word merged in for a write).
- R6: A read produces exactly one `rd_valid` pulse, one cycle long, in the cycle after the sense phase ends. `rd_data` then holds bits `[c*DW +: DW]` of the stored row, where c is the requested column.
- R7: A write replaces only bits `[c*DW +: DW]` of the stored row and leaves the other columns unchanged. A write produces no `rd_valid`.
- R8: One refresh is requested every `REF_PERIOD` cycles. Refreshed rows follow the order 0, 1, …, `ROWS`-1 and then wrap. No row goes longer than `ROWS*REF_PERIOD + 32` cycles without a write-back.
- R9: `req_ready` is low while any strobe is active and while a refresh is pending. An access that has started always runs all its phases.
- R10: During the sense and restore phases of a user access `col_sel` is the one-hot code of the requested column. During a refresh `col_sel` stays all zero.
- R11: While `wl_en` is high, `row_sel` has exactly one bit set, the bit of the addressed row (or of the refresh row), and it does not change until the row closes.
- R12: Between two accesses all strobes stay low for at least `T_CLOSE` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | $clog2(ROWS) | Row address |
| req_col | input | $clog2(COLS) | Column (word) address |
| req_wdata | input | DW | Write word |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DW | Read word |
| pre_en | output | 1 | Bit-line precharge |
| eq_en | output | 1 | Bit-line pair equalize |
| wl_en | output | 1 | Word line enable |
| row_sel | output | ROWS | One-hot row select, active with `wl_en` |
| col_sel | output | COLS | One-hot column select |
| sense_en | output | 1 | Sense amplifier enable |
| wr_drv | output | 1 | Write driver enable (restore) |
| wr_data | output | COLS*DW | Row contents driven during restore |
| arr_rdata | input | COLS*DW | Row contents from the sense amplifiers |

## Verification
The assertions assume that `arr_rdata` stays stable from the word-line settle phase to the end of sensing. They also assume that `REF_PERIOD` is longer than one full access, so a refresh tick can never arrive while an earlier one is still pending. The bench array model holds the sensed row from the settle phase onward and sets the row to zero during sensing, which mimics the destructive read. The bench configuration uses a 40-cycle refresh period against accesses of about ten cycles. Requests are presented only through the handshake, so the stimulus cannot break into an open access. Both back-to-back and gapped traffic keep refresh in contention with user requests.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECH,
        ST_SETTLE,
        ST_SENSE,
        ST_RESTORE,
        ST_CLOSE
    } seq_state_t;
endpackage

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    output logic             last
);
    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= len - LEN_W'(1);
        else if (cnt_q != '0)    cnt_q <= cnt_q - LEN_W'(1);
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/seq_refresh_sched.sv
module seq_refresh_sched #(
    parameter int ROWS       = 8,
    parameter int REF_PERIOD = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    output logic                    pend,
    output logic [$clog2(ROWS)-1:0] row
);
    localparam int RAW = $clog2(ROWS);
    localparam int TW  = $clog2(REF_PERIOD + 1);

    logic [TW-1:0]  tmr_q;
    logic           tick;
    logic           pend_q;
    logic [RAW-1:0] row_q;

    assign tick = (tmr_q == TW'(REF_PERIOD - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q  <= '0;
            pend_q <= 1'b0;
            row_q  <= '0;
        end else begin
            tmr_q  <= tick ? '0 : tmr_q + TW'(1);
            pend_q <= tick | (pend_q & ~take);
            if (take)
                row_q <= (row_q == RAW'(ROWS - 1)) ? '0 : row_q + RAW'(1);
        end
    end

    assign pend = pend_q;
    assign row  = row_q;

    // R8: a new tick never lands on a refresh still waiting
    p_tick_not_lost_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (!pend_q || take));
endmodule

// File: rtl/seq_row_merge.sv
module seq_row_merge #(
    parameter int COLS = 4,
    parameter int DW   = 8
) (
    input  logic [COLS*DW-1:0]       sensed,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(COLS)-1:0]  col,
    input  logic                     wr_en,
    output logic [COLS*DW-1:0]       merged
);
    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign merged[c*DW +: DW] = (wr_en && col == c) ? wdata : sensed[c*DW +: DW];
    end
endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
    import dram_seq_pkg::*;
#(
    parameter int ROWS       = 8,
    parameter int COLS       = 4,
    parameter int DW         = 8,
    parameter int PHASE_W    = 4,
    parameter int T_PRE      = 2,
    parameter int T_WL       = 2,
    parameter int T_SENSE    = 2,
    parameter int T_RST      = 2,
    parameter int T_CLOSE    = 1,
    parameter int REF_PERIOD = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [$clog2(ROWS)-1:0] req_row,
    input  logic [$clog2(COLS)-1:0] req_col,
    input  logic [DW-1:0]           req_wdata,
    output logic                    rd_valid,
    output logic [DW-1:0]           rd_data,
    output logic                    pre_en,
    output logic                    eq_en,
    output logic                    wl_en,
    output logic [ROWS-1:0]         row_sel,
    output logic [COLS-1:0]         col_sel,
    output logic                    sense_en,
    output logic                    wr_drv,
    output logic [COLS*DW-1:0]      wr_data,
    input  logic [COLS*DW-1:0]      arr_rdata
);
    localparam int RAW = $clog2(ROWS);
    localparam int CAW = $clog2(COLS);
    localparam int RW  = COLS * DW;

    seq_state_t       state_q, state_d;
    logic             adv, last, ref_take, ref_pend;
    logic [PHASE_W-1:0] len_d;
    logic [RAW-1:0]   ref_row, row_q;
    logic [CAW-1:0]   col_q;
    logic [DW-1:0]    wdata_q;
    logic             is_wr_q, is_ref_q, rd_valid_q;
    logic [RW-1:0]    row_buf_q, merged;

    seq_phase_timer #(.LEN_W(PHASE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(adv), .len(len_d), .last(last)
    );

    seq_refresh_sched #(.ROWS(ROWS), .REF_PERIOD(REF_PERIOD)) u_refresh (
        .clk(clk), .rst_n(rst_n), .take(ref_take), .pend(ref_pend), .row(ref_row)
    );

    seq_row_merge #(.COLS(COLS), .DW(DW)) u_merge (
        .sensed(arr_rdata), .wdata(wdata_q), .col(col_q),
        .wr_en(is_wr_q & ~is_ref_q), .merged(merged)
    );

    assign req_ready = (state_q == ST_IDLE) && !ref_pend;
    assign ref_take  = (state_q == ST_IDLE) && ref_pend;

    // next state and length of the phase being entered
    always_comb begin
        state_d = state_q;
        len_d   = PHASE_W'(1);
        adv     = 1'b0;
        unique case (state_q)
            ST_IDLE: if (ref_pend || req_valid) begin
                state_d = ST_PRECH;   len_d = PHASE_W'(T_PRE);   adv = 1'b1;
            end
            ST_PRECH: if (last) begin
                state_d = ST_SETTLE;  len_d = PHASE_W'(T_WL);    adv = 1'b1;
            end
            ST_SETTLE: if (last) begin
                state_d = ST_SENSE;   len_d = PHASE_W'(T_SENSE); adv = 1'b1;
            end
            ST_SENSE: if (last) begin
                state_d = ST_RESTORE; len_d = PHASE_W'(T_RST);   adv = 1'b1;
            end
            ST_RESTORE: if (last) begin
                state_d = ST_CLOSE;   len_d = PHASE_W'(T_CLOSE); adv = 1'b1;
            end
            ST_CLOSE: if (last) begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and access context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            row_q      <= '0;
            col_q      <= '0;
            wdata_q    <= '0;
            is_wr_q    <= 1'b0;
            is_ref_q   <= 1'b0;
            rd_valid_q <= 1'b0;
            row_buf_q  <= '0;
        end else begin
            state_q    <= state_d;
            rd_valid_q <= 1'b0;
            if (ref_take) begin
                is_ref_q <= 1'b1;
                is_wr_q  <= 1'b0;
                row_q    <= ref_row;
            end else if (req_ready && req_valid) begin
                is_ref_q <= 1'b0;
                is_wr_q  <= req_write;
                row_q    <= req_row;
                col_q    <= req_col;
                wdata_q  <= req_wdata;
            end
            if (state_q == ST_SENSE && last) begin
                row_buf_q  <= merged;
                rd_valid_q <= !is_ref_q && !is_wr_q;
            end
        end
    end

    // strobe outputs
    always_comb begin
        pre_en   = 1'b0;
        eq_en    = 1'b0;
        wl_en    = 1'b0;
        sense_en = 1'b0;
        wr_drv   = 1'b0;
        unique case (state_q)
            ST_PRECH:   begin pre_en = 1'b1; eq_en = 1'b1; end
            ST_SETTLE:  wl_en = 1'b1;
            ST_SENSE:   begin wl_en = 1'b1; sense_en = 1'b1; end
            ST_RESTORE: begin wl_en = 1'b1; sense_en = 1'b1; wr_drv = 1'b1; end
            default:    ;
        endcase
        row_sel = wl_en ? (ROWS'(1) << row_q) : '0;
        col_sel = ((state_q == ST_SENSE || state_q == ST_RESTORE) && !is_ref_q)
                  ? (COLS'(1) << col_q) : '0;
    end

    assign wr_data  = row_buf_q;
    assign rd_valid = rd_valid_q;
    assign rd_data  = row_buf_q[col_q*DW +: DW];

    p_pre_wl_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pre_en && wl_en));
    p_wl_after_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wl_en) |-> $past(pre_en));
    p_sense_inside_wl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sense_en |-> wl_en);
    p_sense_not_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sense_en) |-> $past(wl_en));
    p_restore_before_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wl_en) |-> $past(wr_drv));
    p_rdvalid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en || wl_en) |-> !req_ready);
    p_row_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wl_en |-> ($countones(row_sel) == 1));
    p_row_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wl_en && $past(wl_en)) |-> $stable(row_sel));
endmodule

// File: tb/dram_strobe_ctrl_tb_top.sv
module dram_strobe_ctrl_tb_top;
    localparam int ROWS = 8, COLS = 4, DW = 8;
    localparam int T_PRE = 2, T_WL = 2, T_SENSE = 2, T_RST = 2, T_CLOSE = 1;
    localparam int REF_PERIOD = 40;
    localparam int RAW = $clog2(ROWS), CAW = $clog2(COLS), RW = COLS * DW;
    localparam int AGE_LIMIT = ROWS * REF_PERIOD + 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [RAW-1:0] req_row = '0;
    logic [CAW-1:0] req_col = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic req_ready, rd_valid, pre_en, eq_en, wl_en, sense_en, wr_drv;
    logic [DW-1:0]   rd_data;
    logic [ROWS-1:0] row_sel;
    logic [COLS-1:0] col_sel;
    logic [RW-1:0]   wr_data, arr_rdata;

    always #10 clk = ~clk;

    dram_strobe_ctrl #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .T_PRE(T_PRE), .T_WL(T_WL),
        .T_SENSE(T_SENSE), .T_RST(T_RST), .T_CLOSE(T_CLOSE), .REF_PERIOD(REF_PERIOD)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .pre_en(pre_en), .eq_en(eq_en),
        .wl_en(wl_en), .row_sel(row_sel), .col_sel(col_sel), .sense_en(sense_en),
        .wr_drv(wr_drv), .wr_data(wr_data), .arr_rdata(arr_rdata));

    int n_checks = 0, n_errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural array: destructive sense, write-back on restore
    logic [RW-1:0] mem [ROWS];
    logic [RW-1:0] open_val = '0;
    assign arr_rdata = open_val;

    function automatic int row_idx(input logic [ROWS-1:0] s);
        int r = -1;
        for (int i = 0; i < ROWS; i++) if (s[i]) r = i;
        return r;
    endfunction

    always @(posedge clk) begin
        int r;
        r = row_idx(row_sel);
        if (r >= 0) begin
            if (wl_en && !sense_en) open_val <= mem[r];
            if (wr_drv) mem[r] <= wr_data;
            else if (sense_en) mem[r] <= '0;
        end
    end

    // scoreboard
    logic [DW-1:0] shadow [ROWS][COLS];
    logic [DW-1:0] exp_q [$];
    int            op_q  [$];

    task automatic do_req(input bit wr, input int row, input int col, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr;
        req_row = RAW'(row); req_col = CAW'(col); req_wdata = d;
        while (!req_ready) @(negedge clk);
        op_q.push_back(row * COLS + col);
        if (wr) shadow[row][col] = d;
        else    exp_q.push_back(shadow[row][col]);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor
    int pre_run = 0, wl_run = 0, rst_run = 0, idle_run = 0;
    int ref_exp = 0, ref_count = 0, cyc = 0;
    bit seen_access = 1'b0, prev_sense = 1'b0, prev_wl = 1'b0, prev_pre = 1'b0;
    int age [ROWS];
    int max_age [ROWS];

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            for (int r = 0; r < ROWS; r++) begin
                age[r]++;
                if (age[r] > max_age[r]) max_age[r] = age[r];
            end
            if (pre_en && !prev_pre) begin
                if (seen_access) chk(idle_run >= T_CLOSE, "R12", "idle gap", idle_run, T_CLOSE);
                chk(!req_ready, "R9", "ready during precharge", req_ready, 0);
                chk(eq_en == 1'b1, "R2", "equalize with precharge", eq_en, 1);
                seen_access = 1'b1;
            end
            if (pre_en) pre_run++;
            else if (pre_run != 0) begin
                chk(pre_run == T_PRE, "R2", "precharge length", pre_run, T_PRE);
                chk(wl_en, "R2", "word line after precharge", wl_en, 1);
                pre_run = 0;
            end
            if (wl_en && !sense_en) wl_run++;
            if (sense_en && !prev_sense) begin
                int r;
                r = row_idx(row_sel);
                chk(wl_run == T_WL, "R4", "word line cycles before sense", wl_run, T_WL);
                if (col_sel == '0) begin
                    chk(r == ref_exp, "R8", "refresh row order", r, ref_exp);
                    ref_exp = (ref_exp + 1) % ROWS;
                    ref_count++;
                end else if (op_q.size() != 0) begin
                    int op;
                    op = op_q.pop_front();
                    chk(r == op / COLS, "R11", "row select", r, op / COLS);
                    chk(col_sel == COLS'(1 << (op % COLS)), "R10", "column select",
                        col_sel, 1 << (op % COLS));
                end else chk(1'b0, "R10", "unexpected user access", 0, 1);
            end
            if (wr_drv) begin
                rst_run++;
                age[row_idx(row_sel)] = 0;
            end
            if (!wl_en && prev_wl) begin
                chk(rst_run == T_RST, "R5", "restore length", rst_run, T_RST);
                rst_run = 0; wl_run = 0;
            end
            if (!pre_en && !wl_en && !sense_en && !wr_drv) idle_run++; else idle_run = 0;
            if (rd_valid) begin
                if (exp_q.size() != 0) begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R6 R7", "read data", rd_data, e);
                end else chk(1'b0, "R6", "extra rd_valid", 1, 0);
            end
            prev_sense = sense_en; prev_wl = wl_en; prev_pre = pre_en;
        end
    end

    initial begin
        for (int r = 0; r < ROWS; r++) begin
            age[r] = 0; max_age[r] = 0;
            for (int c = 0; c < COLS; c++) begin
                shadow[r][c] = DW'(r * 16 + c * 3 + 1);
                mem[r][c*DW +: DW] = DW'(r * 16 + c * 3 + 1);
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(!pre_en && !eq_en && !wl_en && !sense_en && !wr_drv, "R1", "strobes idle", 1, 0);
        chk(row_sel == '0 && col_sel == '0 && !rd_valid, "R1", "selects idle", row_sel, 0);
        chk(req_ready, "R1", "ready after reset", req_ready, 1);
        // directed: read, write, read back, neighbours untouched
        do_req(1'b0, 2, 1, '0);
        do_req(1'b1, 2, 1, 8'hA5);
        do_req(1'b0, 2, 1, '0);
        do_req(1'b0, 2, 0, '0);
        do_req(1'b0, 2, 3, '0);
        do_req(1'b1, 5, 3, 8'h3C);
        do_req(1'b0, 5, 3, '0);
        do_req(1'b0, 5, 3, '0);   // second read: data survived destructive read
        // write produces no rd_valid: queue must stay in step (checked by monitor)
        // continuous traffic
        for (int i = 0; i < 250; i++)
            do_req(1'($urandom_range(0, 1)), $urandom_range(0, ROWS - 1),
                   $urandom_range(0, COLS - 1), DW'($urandom));
        // gapped traffic
        for (int i = 0; i < 60; i++) begin
            repeat ($urandom_range(0, 30)) @(negedge clk);
            do_req(1'($urandom_range(0, 1)), $urandom_range(0, ROWS - 1),
                   $urandom_range(0, COLS - 1), DW'($urandom));
        end
        // final read of every word
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) do_req(1'b0, r, c, '0);
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R6", "reads left unanswered", exp_q.size(), 0);
        chk(ref_count >= cyc / REF_PERIOD - 1, "R8", "refresh count", ref_count, cyc / REF_PERIOD - 1);
        for (int r = 0; r < ROWS; r++)
            chk(max_age[r] <= AGE_LIMIT, "R8", $sformatf("row %0d max age", r), max_age[r], AGE_LIMIT);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule